// File: doc/BRIEF.md
# Serial Memory Bus Slave Engine

This block is the two-wire bus front end of a byte-addressed serial memory. It oversamples the clock and data wires with the system clock, recognises START and STOP conditions, and decodes a seven-bit device select. The select is a fixed four-bit prefix followed by three strap inputs. Once a select is accepted, the engine sequences the whole transaction: it takes in the memory address, hands write data to an external page buffer, or shifts read data out. It drives only the open-drain pull-down of the data wire.

A separate buffer and commit controller sits next to the engine. It takes each accepted data byte together with its address on a one-cycle load strobe. On a commit strobe it starts the internal write cycle, and it raises a busy flag while that cycle runs. While busy is high, the engine refuses its own select, so a master can poll for completion. Read data comes back combinationally from the address the engine presents. A write-protect input is checked once, just before the first data byte. When it is high, that byte is refused and the whole write is dropped.

Top module: `eepromBusSlave`

## Requirements
- R1: Before the first START the bus is ignored and SDA stays released. A STOP returns the engine to idle with SDA released. A START anywhere, even in the middle of a byte, abandons the current transaction and starts a fresh device select.
- R2: The select byte is sent MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal strapIn[2:0]. Bit 0 is the direction, where 1 means read and 0 means write. The engine pulls SDA low in the ninth clock only when the select matches.
- R3: While busyIn is high at the end of a select byte, the select gets no acknowledge. Once busyIn is low again, the same select is acknowledged.
- R4: After a write select, two address bytes follow, high byte first. The byte address is their low ADDR_W bits (13 by default), and the higher bits are ignored. Each accepted data byte is acknowledged and appears for one clock on loadStrb, together with memAddr and wrData.
- R5: Successive data bytes of one write advance the address inside the aligned page of 2^PAGE_BITS bytes (32 by default). After the last byte of the page, the address wraps to the first byte of the same page.
- R6: commitStrb pulses for one clock on a STOP only if at least one data byte has been accepted since the last START. A write that ends after the select or the address bytes does not commit, and neither does a write abandoned by a START.
- R7: wpIn is sampled at the SCL falling edge that ends the acknowledge of the low address byte. If it is high, the first data byte gets no acknowledge, no load and no commit. A change on wpIn after that edge has no effect on the running write.
- R8: In read mode each byte goes out MSB first. A bit changes only after an SCL falling edge. A read select with no address phase sends the byte at the internal pointer, which sits one past the last byte read.
- R9: A write select and two address bytes, followed by a repeated START and a read select, return data starting at the loaded address.
- R10: A master acknowledge after a read byte makes the engine send the byte at the next address, wrapping from 2^ADDR_W-1 to 0. A master no-acknowledge makes the engine release SDA and go idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Level of the bus clock wire |
| sdaIn | input | 1 | Level of the bus data wire |
| sdaDriveLow | output | 1 | 1 pulls the data wire low, 0 releases it |
| strapIn | input | 3 | Static strap levels matched against select bits 3..1 |
| wpIn | input | 1 | Write protect level |
| busyIn | input | 1 | Internal write cycle in progress |
| rdData | input | 8 | Memory byte at memAddr |
| memAddr | output | ADDR_W | Current byte address pointer |
| wrData | output | 8 | Received data byte, valid with loadStrb |
| loadStrb | output | 1 | One-cycle strobe: accepted data byte for the page buffer |
| commitStrb | output | 1 | One-cycle strobe: start the internal write cycle |

## Verification
A miscounted bit counter moves the acknowledge into the wrong clock. The master sees this on the very next ninth clock, as a missing or misplaced low on SDA. A wrong address pointer stays hidden until data moves. It then shows as a wrong memAddr beside loadStrb, or as a wrong byte on the next read, so the sweeps read back each written page and follow reads across the page and memory ends. A stale write-protect or busy decision shows only in the acknowledge of the select or of the first data byte. This is why those slots are checked directly, not just inferred from memory contents later.

// File: rtl/eepromSlavePkg.sv
package eepromSlavePkg;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVSEL, ST_ACKDEV, ST_ADDRHI, ST_ACKHI,
    ST_ADDRLO, ST_ACKLO, ST_WDATA, ST_ACKWD, ST_RDATA, ST_RACK
  } slvState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic incPage;
    logic loadOut;
    logic shiftOut;
  } dpStrobe_t;

endpackage

// File: rtl/busSampler.sv
module busSampler #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [SYNC_DEPTH-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_DEPTH-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_DEPTH-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_DEPTH-1];
      sdaPrev <= sdaPipe[SYNC_DEPTH-1];
    end
  end

  assign sclNow    = sclPipe[SYNC_DEPTH-1];
  assign sdaBit    = sdaPipe[SYNC_DEPTH-1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaBit;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaBit;
endmodule

// File: rtl/slaveDatapath.sv
module slaveDatapath
  import eepromSlavePkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAGE_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaBit,
  input  logic [7:0]        rdData,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int HI_BITS = ADDR_W - 8;
  localparam logic [PAGE_BITS-1:0] PAGE_ONE = PAGE_BITS'(1);
  localparam logic [ADDR_W-1:0]    ADDR_ONE = ADDR_W'(1);

  logic [7:0]        txShift;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '1;
      addr    <= '0;
    end else begin
      if (strb.shiftIn)  rxByte <= {rxByte[6:0], sdaBit};
      if (strb.loadOut)  txShift <= rdData;
      else if (strb.shiftOut) txShift <= {txShift[6:0], 1'b1};
      if (strb.loadHi)   addr[ADDR_W-1:8] <= rxByte[HI_BITS-1:0];
      if (strb.loadLo)   addr[7:0] <= rxByte;
      if (strb.incPage)  addr[PAGE_BITS-1:0] <= addr[PAGE_BITS-1:0] + PAGE_ONE;
      if (strb.loadOut)  addr <= addr + ADDR_ONE;
    end
  end

  assign txBit   = txShift[7];
  assign memAddr = addr;

  // R5
  page_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.incPage |=> ($stable(addr[ADDR_W-1:PAGE_BITS]) &&
                      addr[PAGE_BITS-1:0] == $past(addr[PAGE_BITS-1:0]) + PAGE_ONE));

  // R10
  read_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOut |=> memAddr == $past(memAddr) + ADDR_ONE);
endmodule

// File: rtl/slaveControl.sv
module slaveControl
  import eepromSlavePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaBit,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic [2:0] strapIn,
  input  logic       wpIn,
  input  logic       busyIn,
  output dpStrobe_t  strb,
  output logic       sdaDriveLow,
  output logic       loadStrb,
  output logic       commitStrb
);
  slvState_t state;
  logic [3:0] bitCnt;
  logic rwBit, wpLat, firstData, pending, masterAck;
  logic byteDone, devMatch, quiet, inByte, wpReject;

  assign byteDone = sclFall && (bitCnt == 4'd8);
  assign devMatch = (rxByte[7:4] == DEV_PREFIX) && (rxByte[3:1] == strapIn);
  assign quiet    = !startSeen && !stopSeen;
  assign inByte   = state inside {ST_DEVSEL, ST_ADDRHI, ST_ADDRLO, ST_WDATA, ST_RDATA};
  assign wpReject = firstData && wpLat;

  always_comb begin
    strb       = '0;
    loadStrb   = 1'b0;
    commitStrb = stopSeen && pending;
    if (quiet) begin
      case (state)
        ST_DEVSEL: strb.shiftIn = sclRise;
        ST_ADDRHI: begin strb.shiftIn = sclRise; strb.loadHi = byteDone; end
        ST_ADDRLO: begin strb.shiftIn = sclRise; strb.loadLo = byteDone; end
        ST_WDATA: begin
          strb.shiftIn = sclRise;
          if (byteDone && !wpReject) begin
            loadStrb     = 1'b1;
            strb.incPage = 1'b1;
          end
        end
        ST_ACKDEV: strb.loadOut  = sclFall && rwBit;
        ST_RDATA:  strb.shiftOut = sclFall && (bitCnt != 4'd8);
        ST_RACK:   strb.loadOut  = sclFall && masterAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      rwBit <= 1'b0; wpLat <= 1'b0; firstData <= 1'b0;
      pending <= 1'b0; masterAck <= 1'b0;
    end else if (startSeen) begin
      state <= ST_DEVSEL;
      bitCnt <= '0;
      pending <= 1'b0;
    end else if (stopSeen) begin
      state <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      if (inByte && sclRise) bitCnt <= bitCnt + 4'd1;
      case (state)
        ST_DEVSEL: if (byteDone) begin
          if (devMatch && !busyIn) begin
            state <= ST_ACKDEV;
            rwBit <= rxByte[0];
          end else state <= ST_IDLE;
        end
        ST_ACKDEV: if (sclFall) begin
          bitCnt <= '0;
          state  <= rwBit ? ST_RDATA : ST_ADDRHI;
        end
        ST_ADDRHI: if (byteDone) state <= ST_ACKHI;
        ST_ACKHI:  if (sclFall) begin bitCnt <= '0; state <= ST_ADDRLO; end
        ST_ADDRLO: if (byteDone) state <= ST_ACKLO;
        ST_ACKLO:  if (sclFall) begin
          bitCnt <= '0;
          state <= ST_WDATA;
          wpLat <= wpIn;
          firstData <= 1'b1;
        end
        ST_WDATA: if (byteDone) begin
          if (wpReject) state <= ST_IDLE;
          else begin
            state <= ST_ACKWD;
            pending <= 1'b1;
            firstData <= 1'b0;
          end
        end
        ST_ACKWD: if (sclFall) begin bitCnt <= '0; state <= ST_WDATA; end
        ST_RDATA: if (byteDone) state <= ST_RACK;
        ST_RACK: begin
          if (sclRise) masterAck <= !sdaBit;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_RDATA : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaDriveLow = (state inside {ST_ACKDEV, ST_ACKHI, ST_ACKLO, ST_ACKWD}) ||
                       (state == ST_RDATA && !txBit);

  // R3
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEVSEL && byteDone && busyIn && quiet) |=> (state == ST_IDLE && !sdaDriveLow));
  // R1
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> state == ST_DEVSEL);
  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE && !sdaDriveLow));
  // R4
  load_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrb |=> sdaDriveLow);
  // R7
  wp_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WDATA && byteDone && wpReject && quiet) |=> (!sdaDriveLow && !loadStrb));
endmodule

// File: rtl/eepromBusSlave.sv
module eepromBusSlave
  import eepromSlavePkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BITS  = 5,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [2:0]        strapIn,
  input  logic              wpIn,
  input  logic              busyIn,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        wrData,
  output logic              loadStrb,
  output logic              commitStrb
);
  logic sdaBit, sclRise, sclFall, startSeen, stopSeen, txBit;
  logic [7:0] rxByte;
  dpStrobe_t strb;

  busSampler #(.SYNC_DEPTH(SYNC_DEPTH)) i_sampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaBit(sdaBit), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  slaveControl i_control (
    .clk(clk), .rstN(rstN), .sdaBit(sdaBit), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .rxByte(rxByte), .txBit(txBit),
    .strapIn(strapIn), .wpIn(wpIn), .busyIn(busyIn), .strb(strb),
    .sdaDriveLow(sdaDriveLow), .loadStrb(loadStrb), .commitStrb(commitStrb)
  );

  slaveDatapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit), .rdData(rdData),
    .rxByte(rxByte), .txBit(txBit), .memAddr(memAddr)
  );

  assign wrData = rxByte;
endmodule

// File: tb/test_eepromBusSlave.sv
module test_eepromBusSlave;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int PB = 3;
  localparam int MEM_SIZE = 1 << AW;
  localparam int Q = 8;
  localparam int BUSY_CYCLES = 2000;
  localparam logic [7:0] SEL_W = 8'hAA;
  localparam logic [7:0] SEL_R = 8'hAB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1, sdaLine;
  logic wpIn = 1'b0, clrStage = 1'b0;
  logic [2:0] strapIn = 3'b101;
  logic sdaDriveLow, loadStrb, commitStrb, busyIn;
  logic [7:0] rdData, wrData;
  logic [AW-1:0] memAddr, lastLoadAddr;

  logic [7:0] mem [MEM_SIZE];
  logic [AW-1:0] stAddr [64];
  logic [7:0] stData [64];
  int stCnt, loadCount, commitCount, busyCnt;

  logic [7:0] expMem [MEM_SIZE];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaLine = mSda & ~sdaDriveLow;
  assign busyIn  = (busyCnt != 0);
  assign rdData  = mem[memAddr];

  eepromBusSlave #(.ADDR_W(AW), .PAGE_BITS(PB)) i_eepromBusSlave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow),
    .strapIn(strapIn), .wpIn(wpIn), .busyIn(busyIn), .rdData(rdData),
    .memAddr(memAddr), .wrData(wrData), .loadStrb(loadStrb), .commitStrb(commitStrb)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // buffer and commit model outside the engine
  always @(posedge clk) begin
    if (!rstN) begin
      stCnt <= 0; loadCount <= 0; commitCount <= 0; busyCnt <= 0; lastLoadAddr <= '0;
      for (int i = 0; i < MEM_SIZE; i++) mem[i] <= pat(i);
    end else begin
      if (clrStage) stCnt <= 0;
      if (loadStrb) begin
        stAddr[stCnt[5:0]] <= memAddr;
        stData[stCnt[5:0]] <= wrData;
        stCnt <= stCnt + 1;
        loadCount <= loadCount + 1;
        lastLoadAddr <= memAddr;
      end
      if (commitStrb) begin
        for (int i = 0; i < stCnt; i++) mem[stAddr[i]] <= stData[i];
        stCnt <= 0;
        commitCount <= commitCount + 1;
        busyCnt <= BUSY_CYCLES;
      end else if (busyCnt != 0) busyCnt <= busyCnt - 1;
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startCond();
    mSda = 1'b1; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    mSda = 1'b0; clrStage = 1'b1; waitClk(1); clrStage = 1'b0; waitClk(Q-1);
    mScl = 1'b0; waitClk(2);
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    mSda = 1'b1; waitClk(Q);
  endtask

  task automatic sendBit(bit b);
    mSda = b; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    mScl = 1'b0; waitClk(2);
  endtask

  task automatic sendByte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    mSda = 1'b1; waitClk(Q);
    mScl = 1'b1; waitClk(Q/2);
    ack = !sdaLine; waitClk(Q/2);
    mScl = 1'b0; waitClk(2);
  endtask

  task automatic recvByte(output logic [7:0] b, input bit giveAck);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q);
      mScl = 1'b1; waitClk(Q/2);
      b[i] = sdaLine; waitClk(Q/2);
      mScl = 1'b0;
    end
    waitClk(2);
    mSda = giveAck ? 1'b0 : 1'b1; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    mScl = 1'b0; waitClk(2);
    mSda = 1'b1;
  endtask

  task automatic pollReady(output int tries);
    bit a;
    tries = 0;
    for (int t = 0; t < 40; t++) begin
      startCond(); sendByte(SEL_W, a); stopCond();
      tries++;
      if (a) break;
    end
  endtask

  // selective read of n bytes from addr, each compared with the expected model
  task automatic readCheck(logic [15:0] addr, int n, string tag);
    bit a0, a1, a2, a3;
    logic [7:0] b;
    startCond();
    sendByte(SEL_W, a0); sendByte(addr[15:8], a1); sendByte(addr[7:0], a2);
    startCond();
    sendByte(SEL_R, a3);
    check(a0 && a1 && a2 && a3, {tag, " read setup acks"}, {a0, a1, a2, a3}, 4'hF);
    for (int k = 0; k < n; k++) begin
      int ea = (int'(addr) + k) % MEM_SIZE;
      recvByte(b, k != n - 1);
      check(b == expMem[ea], tag, b, expMem[ea]);
    end
    stopCond();
  endtask

  initial begin
    bit a, a1, a2, a3;
    int tries, lc0, cc0;
    logic [7:0] b;
    for (int i = 0; i < MEM_SIZE; i++) expMem[i] = pat(i);
    waitClk(5); rstN = 1'b1; waitClk(5);

    // R1 reset state
    check(sdaDriveLow == 1'b0, "R1 reset sda released", sdaDriveLow, 0);
    check(loadCount == 0 && commitCount == 0, "R1 reset no strobes", loadCount + commitCount, 0);

    // R1 bus ignored before START
    sendByte(SEL_W, a);
    check(!a, "R1 no ack before START", a, 0);
    stopCond();

    // R2 exhaustive strap sweep; R6 select-only writes never commit
    for (int k = 0; k < 8; k++) begin
      startCond(); sendByte({4'hA, 3'(k), 1'b0}, a); stopCond();
      check(a == (k == 5), "R2 select match", a, k == 5);
    end
    startCond(); sendByte(8'hBA, a); stopCond();
    check(!a, "R2 wrong prefix", a, 0);
    check(commitCount == 0, "R6 no commit without data", commitCount, 0);

    // R4 byte write, high address bits ignored; R6 commit
    startCond();
    sendByte(SEL_W, a); sendByte(8'hF1, a1); sendByte(8'h23, a2); sendByte(8'h5A, a3);
    stopCond();
    expMem[9'h123] = 8'h5A;
    check(a && a1 && a2 && a3, "R4 byte write acks", {a, a1, a2, a3}, 4'hF);
    check(lastLoadAddr == 9'h123, "R4 load address", lastLoadAddr, 9'h123);
    check(loadCount == 1, "R4 load count", loadCount, 1);
    check(commitCount == 1, "R6 commit on STOP", commitCount, 1);

    // R3 busy refuses select, then ready
    startCond(); sendByte(SEL_W, a); stopCond();
    check(!a, "R3 nack while busy", a, 0);
    pollReady(tries);
    check(tries > 1 && tries < 40, "R3 ack after busy", tries, 2);

    // R5 page write with wrap inside an 8-byte page
    lc0 = loadCount;
    startCond();
    sendByte(SEL_W, a); sendByte(8'h00, a1); sendByte(8'h0E, a2);
    tries = int'(a) + int'(a1) + int'(a2);
    for (int k = 0; k < 10; k++) begin
      sendByte(8'(k * 17 + 1), a);
      tries += int'(a);
      expMem[8 + ((6 + k) % 8)] = 8'(k * 17 + 1);
    end
    stopCond();
    check(tries == 13, "R4 page write acks", tries, 13);
    check(loadCount - lc0 == 10, "R4 page load count", loadCount - lc0, 10);
    check(lastLoadAddr == 9'h00F, "R5 page wrap address", lastLoadAddr, 9'h00F);
    pollReady(tries);

    // R9 R10 selective and sequential read across the page
    readCheck(16'h0008, 8, "R9 R10 page readback");

    // R8 current-address read continues after last byte read
    startCond(); sendByte(SEL_R, a);
    recvByte(b, 1'b0); stopCond();
    check(a, "R8 current read ack", a, 1);
    check(b == expMem[9'h010], "R8 current read data", b, expMem[9'h010]);

    // R10 wrap at end of memory
    readCheck(16'h01FE, 4, "R10 memory wrap");

    // R7 write protect rejects the whole write
    lc0 = loadCount; cc0 = commitCount;
    wpIn = 1'b1;
    startCond();
    sendByte(SEL_W, a1); sendByte(8'h00, a2); sendByte(8'h40, a3); sendByte(8'h99, a);
    stopCond();
    wpIn = 1'b0;
    check(a1 && a2 && a3, "R7 address acks", {a1, a2, a3}, 3'h7);
    check(!a, "R7 first data nack", a, 0);
    check(loadCount == lc0 && commitCount == cc0, "R7 no load or commit",
          loadCount - lc0 + commitCount - cc0, 0);

    // R7 protect raised after the sample point has no effect
    startCond();
    sendByte(SEL_W, a); sendByte(8'h00, a); sendByte(8'h41, a);
    sendByte(8'h11, a1);
    wpIn = 1'b1;
    sendByte(8'h22, a2);
    stopCond();
    wpIn = 1'b0;
    expMem[9'h041] = 8'h11; expMem[9'h042] = 8'h22;
    check(a1 && a2, "R7 late protect ignored", {a1, a2}, 2'h3);
    pollReady(tries);
    readCheck(16'h0040, 3, "R7 protect readback");

    // R1 START mid-byte aborts; R6 no commit
    cc0 = commitCount;
    startCond();
    sendByte(SEL_W, a); sendByte(8'h00, a); sendByte(8'h50, a);
    for (int k = 0; k < 4; k++) sendBit(k[0]);
    startCond();
    sendByte(SEL_R, a);
    recvByte(b, 1'b0); stopCond();
    check(a, "R1 select after mid-byte START", a, 1);
    check(b == expMem[9'h050], "R1 read after abort", b, expMem[9'h050]);
    check(commitCount == cc0, "R6 aborted write no commit", commitCount, cc0);
    check(sdaDriveLow == 1'b0, "R10 released after NoACK", sdaDriveLow, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end
endmodule